// File: doc/BRIEF.md
# Near-Memory Gather-Reduce Unit

This block is the per-rank engine of a memory buffer chip. It takes compact near-memory instructions through a valid/ready handshake. Each instruction names one embedding vector: a command type (plain or weighted accumulation), a DRAM row and column, a burst length in beats, a partial-sum tag, a locality flag, a last-in-group flag and a 16-bit weight. For each instruction the unit drives activate, read and precharge commands at its single DRAM rank, spacing them by the row-to-column, CAS and precharge delays given as parameters.

The unit views each returned 64-bit beat as four signed 16-bit elements. It adds them, either as they are or scaled by the weight, into a bank of 32-bit lane accumulators. The last instruction of a group ends the reduction. The finished vector then leaves the unit for one cycle with that instruction's tag, and the accumulators return to zero.

The locality flag chooses the page policy. A flagged access leaves its row open, so a later instruction to the same row reads without a new activate. An unflagged access closes the row once its data has arrived.

Top module: `nmp_reduce_unit`

## Requirements
- R1: After reset, instReady is 1, psumValid is 0 and dramCmd is NOP. The command encoding is NOP=0, ACT=1, RD=2, PRE=3.
- R2: In the cycle after an instruction is accepted (instValid and instReady high at a clock edge), instReady is 0. It stays 0 until that instruction's data has been accumulated.
- R3: A RD follows the ACT that opened its row by at least TRCD cycles. dramAddr carries the row during ACT and the column during RD.
- R4: An ACT follows the most recent PRE by at least TRP cycles.
- R5: instLocal=0 closes the row with a PRE after the last data beat. instLocal=1 leaves the row open. A later instruction to the open row issues RD without ACT. A later instruction to another row first issues PRE and then ACT.
- R6: instOp=0 adds each signed 16-bit element (element e of a beat at bits 16e+15:16e) into its 32-bit lane with wrap-around, and instWeight has no effect.
- R7: instOp=1 adds (element × instWeight) >>> 8 per lane. The weight is signed fixed point with 8 fraction bits.
- R8: Only the first instBurst beats of a vector are accumulated, into lanes 4b..4b+3 for beat b. A burst value of 0, or any value above the beats per vector, means a full vector.
- R9: An instruction with instLast=1 raises psumValid for exactly one cycle after its data, with psumTag equal to its tag. psumData holds the sum of the group, lane i at bits 32i+31:32i. The next group starts from zero.
- R10: dramRdValid is ignored unless a read is outstanding and at least TCL cycles have passed since its RD.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| instValid | input | 1 | Instruction present |
| instReady | output | 1 | Unit can take an instruction |
| instOp | input | 1 | 0 plain sum, 1 weighted sum |
| instRow | input | ROW_W | DRAM row |
| instCol | input | COL_W | DRAM column |
| instBurst | input | $clog2(BEATS+1) | Beats to fetch, 0 = full vector |
| instTag | input | TAG_W | Partial-sum tag |
| instLocal | input | 1 | Keep row open after access |
| instLast | input | 1 | Ends the reduction group |
| instWeight | input | 16 | Signed weight, 8 fraction bits |
| dramCmd | output | 2 | Command to the rank |
| dramAddr | output | max(ROW_W,COL_W) | Row on ACT, column on RD |
| dramRdValid | input | 1 | Read beat valid |
| dramRdData | input | 64 | Read beat |
| psumValid | output | 1 | Finished partial sum, one cycle |
| psumTag | output | TAG_W | Tag of the finished sum |
| psumData | output | BEATS*4*32 | Finished lane sums |

## Verification
The bench builds the unit with TRCD=4, TCL=3 and TRP=5: three distinct small values, so a swapped or off-by-one delay shows up in the command spacing that a rank model measures at every ACT and RD. Rows and columns are narrowed to 8 and 6 bits, while the default 64-byte vector keeps all 32 lanes and full-length bursts in play. The short delays leave room, within a brief run, for open-row hits, row conflicts, clipped bursts, negative weights and a stray data beat while the unit is idle.

// File: rtl/nrd_pkg.sv
package nrd_pkg;
  localparam int BEAT_W = 64;
  localparam int ELEM_W = 16;
  localparam int LANES  = BEAT_W / ELEM_W;
  localparam int ACC_W  = 32;
  localparam int WGT_W  = 16;
  localparam int FRAC   = 8;

  typedef enum logic [1:0] {
    CMD_NOP = 2'd0,
    CMD_ACT = 2'd1,
    CMD_RD  = 2'd2,
    CMD_PRE = 2'd3
  } dram_cmd_e;

  typedef enum logic [2:0] {
    S_IDLE, S_PRE, S_ACTW, S_RDW, S_DATA, S_CLOSE, S_FIN
  } ctrl_state_e;

  typedef struct packed {
    logic load;
    logic accum;
    logic emit;
  } nrd_strobe_t;
endpackage

// File: rtl/nrd_lane_scale.sv
module nrd_lane_scale
  import nrd_pkg::*;
(
  input  logic [ELEM_W-1:0] elem,
  input  logic [WGT_W-1:0]  weight,
  input  logic              weighted,
  output logic [ACC_W-1:0]  term
);
  localparam int PW = ELEM_W + WGT_W;

  logic signed [PW-1:0] prod;
  logic signed [PW-1:0] scaled;

  assign prod   = $signed(elem) * $signed(weight);
  assign scaled = prod >>> FRAC;

  always_comb begin
    if (weighted) term = ACC_W'(scaled);
    else          term = ACC_W'($signed(elem));
  end
endmodule

// File: rtl/nrd_ctrl.sv
module nrd_ctrl
  import nrd_pkg::*;
#(
  parameter int ROW_W = 14,
  parameter int COL_W = 10,
  parameter int BEATS = 8,
  parameter int TRCD  = 16,
  parameter int TCL   = 16,
  parameter int TRP   = 16,
  localparam int DA_W = (ROW_W > COL_W) ? ROW_W : COL_W,
  localparam int BI_W = $clog2(BEATS),
  localparam int BL_W = $clog2(BEATS + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             instValid,
  output logic             instReady,
  input  logic [ROW_W-1:0] instRow,
  input  logic [COL_W-1:0] instCol,
  input  logic [BL_W-1:0]  instBurst,
  input  logic             instLocal,
  input  logic             instLast,
  output dram_cmd_e        dramCmd,
  output logic [DA_W-1:0]  dramAddr,
  input  logic             dramRdValid,
  output nrd_strobe_t      strobes,
  output logic [BI_W-1:0]  beatIdx
);
  localparam int RCD_W = $clog2(TRCD + 1);
  localparam int RP_W  = $clog2(TRP + 1);
  localparam int CL_W  = $clog2(TCL + 1);

  ctrl_state_e      state;
  logic             rowOpen;
  logic [ROW_W-1:0] openRow;
  logic [ROW_W-1:0] rowR;
  logic [COL_W-1:0] colR;
  logic [BL_W-1:0]  blR;
  logic             locR;
  logic             lastR;
  logic [RCD_W-1:0] rcdCnt;
  logic [RP_W-1:0]  rpCnt;
  logic [CL_W-1:0]  sinceRd;
  logic [BL_W-1:0]  beatCnt;
  logic [BL_W-1:0]  effBurst;
  logic             takeBeat;

  always_comb begin
    if (instBurst == '0 || instBurst > BL_W'(BEATS)) effBurst = BL_W'(BEATS);
    else                                              effBurst = instBurst;
  end

  assign instReady = (state == S_IDLE);
  assign takeBeat  = (state == S_DATA) && dramRdValid && (sinceRd == CL_W'(TCL));

  always_comb begin
    dramCmd  = CMD_NOP;
    dramAddr = '0;
    unique case (state)
      S_PRE, S_CLOSE: dramCmd = CMD_PRE;
      S_ACTW: if (rpCnt == '0) begin
        dramCmd  = CMD_ACT;
        dramAddr = DA_W'(rowR);
      end
      S_RDW: if (rcdCnt == '0) begin
        dramCmd  = CMD_RD;
        dramAddr = DA_W'(colR);
      end
      default: ;
    endcase
  end

  always_comb begin
    strobes.load  = instReady && instValid;
    strobes.accum = takeBeat;
    strobes.emit  = (state == S_FIN) && lastR;
  end
  assign beatIdx = beatCnt[BI_W-1:0];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rcdCnt  <= '0;
      rpCnt   <= '0;
      sinceRd <= '0;
    end else begin
      if (dramCmd == CMD_ACT)  rcdCnt <= RCD_W'(TRCD - 1);
      else if (rcdCnt != '0)   rcdCnt <= rcdCnt - 1'b1;
      if (dramCmd == CMD_PRE)  rpCnt <= RP_W'(TRP - 1);
      else if (rpCnt != '0)    rpCnt <= rpCnt - 1'b1;
      if (dramCmd == CMD_RD)             sinceRd <= CL_W'(1);
      else if (sinceRd != CL_W'(TCL))    sinceRd <= sinceRd + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= S_IDLE;
      rowOpen <= 1'b0;
      openRow <= '0;
      rowR    <= '0;
      colR    <= '0;
      blR     <= '0;
      locR    <= 1'b0;
      lastR   <= 1'b0;
      beatCnt <= '0;
    end else begin
      unique case (state)
        S_IDLE: if (instValid) begin
          rowR  <= instRow;
          colR  <= instCol;
          blR   <= effBurst;
          locR  <= instLocal;
          lastR <= instLast;
          if (rowOpen && openRow == instRow) state <= S_RDW;
          else if (rowOpen)                  state <= S_PRE;
          else                               state <= S_ACTW;
        end
        S_PRE: begin
          rowOpen <= 1'b0;
          state   <= S_ACTW;
        end
        S_ACTW: if (rpCnt == '0) begin
          rowOpen <= 1'b1;
          openRow <= rowR;
          state   <= S_RDW;
        end
        S_RDW: if (rcdCnt == '0) begin
          beatCnt <= '0;
          state   <= S_DATA;
        end
        S_DATA: if (takeBeat) begin
          beatCnt <= beatCnt + 1'b1;
          if (beatCnt == blR - 1'b1) state <= locR ? S_FIN : S_CLOSE;
        end
        S_CLOSE: begin
          rowOpen <= 1'b0;
          state   <= S_FIN;
        end
        S_FIN:   state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  // Independent spacing monitors for the timing checks below.
  logic [RCD_W-1:0] sinceAct;
  logic [RP_W-1:0]  sincePre;
  always_ff @(posedge clk) begin
    if (!rstN) begin
      sinceAct <= '0;
      sincePre <= RP_W'(TRP);
    end else begin
      if (dramCmd == CMD_ACT)               sinceAct <= RCD_W'(1);
      else if (sinceAct != RCD_W'(TRCD))    sinceAct <= sinceAct + 1'b1;
      if (dramCmd == CMD_PRE)               sincePre <= RP_W'(1);
      else if (sincePre != RP_W'(TRP))      sincePre <= sincePre + 1'b1;
    end
  end

  a_r3_act_to_rd: assert property (@(posedge clk) disable iff (!rstN)
    dramCmd == CMD_RD |-> sinceAct == RCD_W'(TRCD));
  a_r4_pre_to_act: assert property (@(posedge clk) disable iff (!rstN)
    dramCmd == CMD_ACT |-> sincePre == RP_W'(TRP));
  a_r5_rd_on_open_row: assert property (@(posedge clk) disable iff (!rstN)
    dramCmd == CMD_RD |-> rowOpen && openRow == rowR);
  a_r2_busy_after_accept: assert property (@(posedge clk) disable iff (!rstN)
    instValid && instReady |=> !instReady);
  a_r10_no_beat_when_idle: assert property (@(posedge clk) disable iff (!rstN)
    instReady |-> !strobes.accum);
endmodule

// File: rtl/nrd_datapath.sv
module nrd_datapath
  import nrd_pkg::*;
#(
  parameter int BEATS = 8,
  parameter int TAG_W = 8,
  localparam int BI_W   = $clog2(BEATS),
  localparam int NLANES = BEATS * LANES
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  nrd_strobe_t             strobes,
  input  logic [BI_W-1:0]         beatIdx,
  input  logic                    instOp,
  input  logic [WGT_W-1:0]        instWeight,
  input  logic [TAG_W-1:0]        instTag,
  input  logic [BEAT_W-1:0]       dramRdData,
  output logic                    psumValid,
  output logic [TAG_W-1:0]        psumTag,
  output logic [NLANES*ACC_W-1:0] psumData
);
  logic             opR;
  logic [WGT_W-1:0] weightR;
  logic [TAG_W-1:0] tagR;
  logic [ACC_W-1:0] acc  [NLANES];
  logic [ACC_W-1:0] term [LANES];

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    nrd_lane_scale u_scale (
      .elem    (dramRdData[l*ELEM_W +: ELEM_W]),
      .weight  (weightR),
      .weighted(opR),
      .term    (term[l])
    );
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      opR     <= 1'b0;
      weightR <= '0;
      tagR    <= '0;
    end else if (strobes.load) begin
      opR     <= instOp;
      weightR <= instWeight;
      tagR    <= instTag;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NLANES; i++) acc[i] <= '0;
      psumValid <= 1'b0;
      psumTag   <= '0;
      psumData  <= '0;
    end else begin
      psumValid <= strobes.emit;
      if (strobes.emit) begin
        psumTag <= tagR;
        for (int i = 0; i < NLANES; i++) begin
          psumData[i*ACC_W +: ACC_W] <= acc[i];
          acc[i] <= '0;
        end
      end else if (strobes.accum) begin
        for (int b = 0; b < BEATS; b++) begin
          if (BI_W'(b) == beatIdx) begin
            for (int l = 0; l < LANES; l++) acc[b*LANES+l] <= acc[b*LANES+l] + term[l];
          end
        end
      end
    end
  end

  a_r9_emit_single_cycle: assert property (@(posedge clk) disable iff (!rstN)
    psumValid |=> !psumValid);
  a_r9_no_mix_emit_accum: assert property (@(posedge clk) disable iff (!rstN)
    !(strobes.emit && strobes.accum));
endmodule

// File: rtl/nmp_reduce_unit.sv
module nmp_reduce_unit
  import nrd_pkg::*;
#(
  parameter int ROW_W     = 14,
  parameter int COL_W     = 10,
  parameter int TAG_W     = 8,
  parameter int VEC_BYTES = 64,
  parameter int TRCD      = 16,
  parameter int TCL       = 16,
  parameter int TRP       = 16,
  localparam int BEATS  = VEC_BYTES * 8 / BEAT_W,
  localparam int BL_W   = $clog2(BEATS + 1),
  localparam int BI_W   = $clog2(BEATS),
  localparam int DA_W   = (ROW_W > COL_W) ? ROW_W : COL_W,
  localparam int NLANES = BEATS * LANES
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    instValid,
  output logic                    instReady,
  input  logic                    instOp,
  input  logic [ROW_W-1:0]        instRow,
  input  logic [COL_W-1:0]        instCol,
  input  logic [BL_W-1:0]         instBurst,
  input  logic [TAG_W-1:0]        instTag,
  input  logic                    instLocal,
  input  logic                    instLast,
  input  logic [WGT_W-1:0]        instWeight,
  output logic [1:0]              dramCmd,
  output logic [DA_W-1:0]         dramAddr,
  input  logic                    dramRdValid,
  input  logic [BEAT_W-1:0]       dramRdData,
  output logic                    psumValid,
  output logic [TAG_W-1:0]        psumTag,
  output logic [NLANES*ACC_W-1:0] psumData
);
  nrd_strobe_t     strobes;
  logic [BI_W-1:0] beatIdx;
  dram_cmd_e       cmdE;

  assign dramCmd = cmdE;

  nrd_ctrl #(
    .ROW_W(ROW_W), .COL_W(COL_W), .BEATS(BEATS),
    .TRCD(TRCD), .TCL(TCL), .TRP(TRP)
  ) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .instValid  (instValid),
    .instReady  (instReady),
    .instRow    (instRow),
    .instCol    (instCol),
    .instBurst  (instBurst),
    .instLocal  (instLocal),
    .instLast   (instLast),
    .dramCmd    (cmdE),
    .dramAddr   (dramAddr),
    .dramRdValid(dramRdValid),
    .strobes    (strobes),
    .beatIdx    (beatIdx)
  );

  nrd_datapath #(
    .BEATS(BEATS), .TAG_W(TAG_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .beatIdx   (beatIdx),
    .instOp    (instOp),
    .instWeight(instWeight),
    .instTag   (instTag),
    .dramRdData(dramRdData),
    .psumValid (psumValid),
    .psumTag   (psumTag),
    .psumData  (psumData)
  );
endmodule

// File: tb/sim_nmp_reduce_unit.sv
module sim_nmp_reduce_unit;
  localparam int ROW_W = 8;
  localparam int COL_W = 6;
  localparam int TAG_W = 6;
  localparam int TRCD  = 4;
  localparam int TCL   = 3;
  localparam int TRP   = 5;
  localparam int BEATS = 8;
  localparam int LANES = 4;
  localparam int NL    = BEATS * LANES;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic instValid = 1'b0;
  logic instReady;
  logic instOp = 1'b0;
  logic [ROW_W-1:0] instRow = '0;
  logic [COL_W-1:0] instCol = '0;
  logic [3:0] instBurst = '0;
  logic [TAG_W-1:0] instTag = '0;
  logic instLocal = 1'b0;
  logic instLast = 1'b0;
  logic [15:0] instWeight = '0;
  logic [1:0] dramCmd;
  logic [7:0] dramAddr;
  logic rankValid = 1'b0;
  logic [63:0] rankData = '0;
  logic strayValid = 1'b0;
  logic dramRdValid;
  logic [63:0] dramRdData;
  logic psumValid;
  logic [TAG_W-1:0] psumTag;
  logic [NL*32-1:0] psumData;

  assign dramRdValid = rankValid | strayValid;
  assign dramRdData  = strayValid ? 64'h7fff_7fff_7fff_7fff : rankData;

  always #5 clk = ~clk;

  nmp_reduce_unit #(
    .ROW_W(ROW_W), .COL_W(COL_W), .TAG_W(TAG_W), .VEC_BYTES(64),
    .TRCD(TRCD), .TCL(TCL), .TRP(TRP)
  ) u0 (
    .clk(clk), .rstN(rstN), .instValid(instValid), .instReady(instReady),
    .instOp(instOp), .instRow(instRow), .instCol(instCol), .instBurst(instBurst),
    .instTag(instTag), .instLocal(instLocal), .instLast(instLast),
    .instWeight(instWeight), .dramCmd(dramCmd), .dramAddr(dramAddr),
    .dramRdValid(dramRdValid), .dramRdData(dramRdData),
    .psumValid(psumValid), .psumTag(psumTag), .psumData(psumData)
  );

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  int expAcc [NL];
  int nAct = 0, nPre = 0, nRd = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int elemVal(input int r, input int c, input int b, input int e);
    return ((r * 37 + c * 13 + b * 7 + e * 29) % 251) - 125;
  endfunction

  // Behavioural rank: tracks the open row, checks spacing, returns data.
  bit rankOpen = 0;
  int rankRow = 0;
  int lastAct = -1000, lastPre = -1000;
  int rdStart = -1000, rdCol = 0, rdRow = 0;
  always @(negedge clk) begin
    int k;
    k = cyc - rdStart;
    if (rstN && k >= 0 && k < BEATS) begin
      rankValid <= 1'b1;
      for (int e = 0; e < LANES; e++)
        rankData[e*16 +: 16] <= 16'(elemVal(rdRow, rdCol, k, e));
    end else begin
      rankValid <= 1'b0;
    end
    if (rstN) begin
      case (dramCmd)
        2'd1: begin
          nAct++;
          check(!rankOpen, "R5", "ACT while row open", 1, 0);
          check(cyc - lastAct >= 0 && cyc - lastPre >= TRP, "R4", "PRE to ACT gap",
                cyc - lastPre, TRP);
          rankOpen = 1; rankRow = dramAddr; lastAct = cyc;
        end
        2'd2: begin
          nRd++;
          check(rankOpen, "R5", "RD with no open row", 0, 1);
          check(cyc - lastAct >= TRCD, "R3", "ACT to RD gap", cyc - lastAct, TRCD);
          rdStart = cyc + TCL; rdCol = dramAddr; rdRow = rankRow;
        end
        2'd3: begin
          nPre++;
          rankOpen = 0; lastPre = cyc;
        end
        default: ;
      endcase
    end
  end

  // Rank window covers BEATS beats; the unit must take only its burst.
  task automatic issue(input bit op, input int row, input int col, input int bl,
                       input int tag, input bit loc, input bit last, input int w);
    int eff;
    @(negedge clk);
    instOp = op; instRow = ROW_W'(row); instCol = COL_W'(col); instBurst = 4'(bl);
    instTag = TAG_W'(tag); instLocal = loc; instLast = last; instWeight = 16'(w);
    instValid = 1'b1;
    while (!instReady) @(negedge clk);
    @(negedge clk);
    instValid = 1'b0;
    check(instReady == 1'b0, "R2", "ready after accept", instReady, 0);
    eff = (bl == 0 || bl > BEATS) ? BEATS : bl;
    for (int b = 0; b < eff; b++)
      for (int e = 0; e < LANES; e++) begin
        int v;
        int ws;
        v = elemVal(row, col, b, e);
        ws = int'($signed(16'(w)));
        expAcc[b*LANES+e] += op ? ((v * ws) >>> 8) : v;
      end
  endtask

  task automatic clearExp();
    for (int i = 0; i < NL; i++) expAcc[i] = 0;
  endtask

  task automatic waitEmit(input int tag, input string req);
    int n = 0;
    int bad = -1;
    while (!psumValid && n < 400) begin @(negedge clk); n++; end
    check(psumValid == 1'b1, req, "psumValid seen", psumValid, 1);
    check(psumTag == TAG_W'(tag), req, "psumTag", psumTag, tag);
    for (int i = 0; i < NL; i++)
      if (bad < 0 && $signed(psumData[i*32 +: 32]) != expAcc[i]) bad = i;
    if (bad < 0) check(1, req, "lanes", 0, 0);
    else check(0, req, $sformatf("lane %0d", bad), $signed(psumData[bad*32 +: 32]), expAcc[bad]);
    @(negedge clk);
    check(psumValid == 1'b0, "R9", "psumValid one cycle", psumValid, 0);
  endtask

  task automatic waitIdle();
    int n = 0;
    while (!instReady && n < 400) begin @(negedge clk); n++; end
  endtask

  task automatic t_reset();
    @(negedge clk);
    check(instReady == 1'b1, "R1", "ready at reset", instReady, 1);
    check(psumValid == 1'b0, "R1", "psumValid at reset", psumValid, 0);
    check(dramCmd == 2'd0, "R1", "cmd at reset", dramCmd, 0);
  endtask

  // R6 plain sum with closed pages, R10 stray beat while idle.
  task automatic t_plain();
    int a0, p0;
    clearExp(); a0 = nAct; p0 = nPre;
    issue(0, 1, 3, 8, 5, 0, 0, 16'h7abc);
    waitIdle();
    @(negedge clk); strayValid = 1'b1;
    @(negedge clk); strayValid = 1'b0;
    issue(0, 2, 7, 8, 6, 0, 0, 16'h0100);
    issue(0, 1, 9, 0, 9, 0, 1, 16'h8000);
    waitEmit(9, "R6");
    check(nAct - a0 == 3, "R5", "ACT count closed page", nAct - a0, 3);
    check(nPre - p0 == 3, "R5", "PRE count closed page", nPre - p0, 3);
    check(!rankOpen, "R5", "row closed after local=0", rankOpen, 0);
  endtask

  // R7 weighted sum, R5 open-row hit and conflict.
  task automatic t_weighted();
    int a0, p0;
    clearExp(); a0 = nAct; p0 = nPre;
    issue(1, 5, 1, 8, 0, 1, 0, 16'h0180);
    issue(1, 5, 4, 8, 0, 1, 0, 16'hff40);
    check(nAct - a0 == 1, "R5", "row hit skips ACT", nAct - a0, 1);
    issue(1, 6, 2, 8, 42, 1, 1, 16'h0040);
    waitEmit(42, "R7");
    check(nAct - a0 == 2, "R5", "conflict ACT count", nAct - a0, 2);
    check(nPre - p0 == 1, "R5", "conflict PRE count", nPre - p0, 1);
    check(rankOpen && rankRow == 6, "R5", "row left open", rankRow, 6);
  endtask

  // R8 clipped bursts, and accumulator restart from zero (R9).
  task automatic t_burst();
    clearExp();
    issue(0, 9, 5, 3, 0, 0, 0, 0);
    issue(1, 9, 6, 15, 0, 0, 0, 16'h0200);
    issue(0, 10, 8, 1, 17, 0, 1, 0);
    waitEmit(17, "R8");
    clearExp();
    issue(0, 11, 2, 2, 33, 1, 1, 0);
    waitEmit(33, "R9");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    fork
      begin
        t_reset();
        t_plain();
        t_weighted();
        t_burst();
        repeat (5) @(negedge clk);
      end
      begin
        wait (cyc >= 20000);
        check(0, "R1", "watchdog expired", cyc, 20000);
      end
    join_any
    disable fork;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule